// File: doc/BRIEF.md
# Packed 52-bit Low Multiply-Accumulate Unit

This block is a pipelined vector datapath that splits a 512-bit operand into eight 64-bit lanes. In every active lane it takes the low 52 bits of the two source operands and multiplies them. It keeps the low 52 bits of the 104-bit product and adds them to the lane's 64-bit accumulator value. The 64-bit sum wraps.

Each lane can be enabled by its own mask bit. A lane that is masked off is either cleared or given back its accumulator value unchanged. A broadcast option feeds the lowest element of the second source into every lane. A length select limits the operation to the lowest 2, 4 or 8 lanes, and every result lane above that length reads zero.

The unit accepts one operation per clock. Each result appears a fixed three cycles after its operation enters, and a valid flag travels with the data.

Top module: `madd52lo_unit`

## Requirements
- R1: An operation presented with `in_valid_i` high at clock edge k appears on `result_o` with `out_valid_o` high after edge k+2, which is three cycles of latency. A new operation is accepted on every cycle, and `out_valid_o` is high only for issued operations.
- R2: While `rst_ni` is low, `out_valid_o` is low. An operation in flight when reset is asserted never produces a valid output.
- R3: Bits 63:52 of every 64-bit element of `src_a_i` and `src_b_i` have no effect on `result_o`.
- R4: An enabled lane j produces `(acc_j + ((a_j mod 2^52) * (b_j mod 2^52) mod 2^52)) mod 2^64`. Lane j occupies bits `[64j+63:64j]`, and any carry out of bit 63 is dropped.
- R5: `vlen_i` = 0 activates lanes 0-1, `vlen_i` = 1 activates lanes 0-3, and `vlen_i` = 2 or 3 activates all eight lanes. Every lane above the active set outputs zero, whatever the mask settings.
- R6: With `mask_en_i` low, every active lane receives the sum of R4.
- R7: With `mask_en_i` high, active lane j receives the sum exactly when `mask_i[j]` is 1.
- R8: With `mask_en_i` high and `zero_mode_i` = 1, an active lane whose mask bit is 0 outputs zero.
- R9: With `mask_en_i` high and `zero_mode_i` = 0, an active lane whose mask bit is 0 outputs its `acc_i` element unchanged.
- R10: With `bcast_i` = 1, bits 51:0 of element 0 of `src_b_i` are used as the second factor in every lane, in place of that lane's own element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present on the inputs |
| src_a_i | input | 512 | First factor vector, eight 64-bit elements |
| src_b_i | input | 512 | Second factor vector, eight 64-bit elements |
| acc_i | input | 512 | Accumulator vector |
| mask_i | input | 8 | Per-lane enable; bit j controls lane j |
| mask_en_i | input | 1 | 1 = apply `mask_i`, 0 = enable all lanes |
| zero_mode_i | input | 1 | 1 = clear masked-off lanes, 0 = keep the accumulator |
| bcast_i | input | 1 | 1 = use element 0 of `src_b_i` in every lane |
| vlen_i | input | 2 | Active length: 0 = 2 lanes, 1 = 4 lanes, 2 or 3 = 8 lanes |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 512 | Result vector |

## Verification
A lane-control code latched into the wrong stage would show up in the first result after the fault. That result would be a stray accumulator value, a zero where a sum belongs, or a sum in a lane above the active length, and it reaches the ports three cycles after the faulty operation enters. A broken valid shift register would move or drop `out_valid_o` for that same operation, which the latency check catches within a cycle. An arithmetic slip, such as upper source bits leaking in, the wrong product half, or a lost wrap, needs operands that expose it. All-ones factors and saturated accumulators expose it in the very first result they produce.

// File: rtl/madd52lo_pkg.sv
package madd52lo_pkg;

  // Per-lane action chosen at issue and carried down the pipe
  typedef enum logic [1:0] {
    LANE_SUM   = 2'd0,
    LANE_KEEP  = 2'd1,
    LANE_CLEAR = 2'd2
  } lane_op_e;

endpackage

// File: rtl/madd52lo_lane_ctrl.sv
module madd52lo_lane_ctrl
  import madd52lo_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int VLEN_W = 2
) (
  input  logic [VLEN_W-1:0] vlen_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic [LANES-1:0]  mask_i,
  output lane_op_e          op_o [LANES]
);

  for (genvar j = 0; j < LANES; j++) begin : g_op
    localparam int unsigned PAIR = j / 2;
    logic active;
    // length code n enables lanes below 2 << n
    assign active = PAIR < (32'd1 << vlen_i);

    always_comb begin
      if (!active)                      op_o[j] = LANE_CLEAR;
      else if (!mask_en_i || mask_i[j]) op_o[j] = LANE_SUM;
      else if (zero_mode_i)             op_o[j] = LANE_CLEAR;
      else                              op_o[j] = LANE_KEEP;
    end
  end

endmodule

// File: rtl/madd52lo_lane.sv
module madd52lo_lane
  import madd52lo_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int MUL_W  = 52
) (
  input  logic              clk_i,
  input  logic              s2_en_i,
  input  logic              s3_en_i,
  input  logic [MUL_W-1:0]  a_i,
  input  logic [MUL_W-1:0]  b_i,
  input  logic [LANE_W-1:0] acc_i,
  input  lane_op_e          op_i,
  output logic [LANE_W-1:0] res_o
);

  logic [MUL_W-1:0]  prod_q;
  logic [LANE_W-1:0] acc_q;
  lane_op_e          op_q;
  logic [LANE_W-1:0] sum;

  // Product taken at operand width: only the low half survives
  always_ff @(posedge clk_i) begin
    if (s2_en_i) begin
      prod_q <= a_i * b_i;
      acc_q  <= acc_i;
      op_q   <= op_i;
    end
  end

  assign sum = acc_q + LANE_W'(prod_q);

  always_ff @(posedge clk_i) begin
    if (s3_en_i) begin
      unique case (op_q)
        LANE_SUM:  res_o <= sum;
        LANE_KEEP: res_o <= acc_q;
        default:   res_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/madd52lo_unit.sv
module madd52lo_unit
  import madd52lo_pkg::*;
#(
  parameter  int LANES  = 8,
  parameter  int LANE_W = 64,
  parameter  int MUL_W  = 52,
  parameter  int VLEN_W = 2,
  localparam int VEC_W  = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  input  logic [VEC_W-1:0]  acc_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic              bcast_i,
  input  logic [VLEN_W-1:0] vlen_i,
  output logic              out_valid_o,
  output logic [VEC_W-1:0]  result_o
);

  localparam int HI_W   = LANE_W - MUL_W;
  localparam int STAGES = 3;

  logic [STAGES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[STAGES-2:0], in_valid_i};
  end

  assign out_valid_o = vld_q[STAGES-1];

  lane_op_e op_d [LANES];

  madd52lo_lane_ctrl #(
    .LANES  (LANES),
    .VLEN_W (VLEN_W)
  ) u_ctrl (
    .vlen_i      (vlen_i),
    .mask_en_i   (mask_en_i),
    .zero_mode_i (zero_mode_i),
    .mask_i      (mask_i),
    .op_o        (op_d)
  );

  // Upper element bits never take part in the arithmetic
  logic [LANES-1:0] unused_hi;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [MUL_W-1:0]  a_q;
    logic [MUL_W-1:0]  b_q;
    logic [LANE_W-1:0] acc_q;
    lane_op_e          op_q;
    logic [MUL_W-1:0]  b_d;

    assign b_d = bcast_i ? src_b_i[MUL_W-1:0] : src_b_i[j*LANE_W +: MUL_W];
    assign unused_hi[j] = ^{src_a_i[j*LANE_W+MUL_W +: HI_W],
                            src_b_i[j*LANE_W+MUL_W +: HI_W]};

    always_ff @(posedge clk_i) begin
      if (in_valid_i) begin
        a_q   <= src_a_i[j*LANE_W +: MUL_W];
        b_q   <= b_d;
        acc_q <= acc_i[j*LANE_W +: LANE_W];
        op_q  <= op_d[j];
      end
    end

    madd52lo_lane #(
      .LANE_W (LANE_W),
      .MUL_W  (MUL_W)
    ) u_lane (
      .clk_i   (clk_i),
      .s2_en_i (vld_q[0]),
      .s3_en_i (vld_q[1]),
      .a_i     (a_q),
      .b_i     (b_q),
      .acc_i   (acc_q),
      .op_i    (op_q),
      .res_o   (result_o[j*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/madd52lo_unit_chk.sv
module madd52lo_unit_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int VLEN_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [LANES*LANE_W-1:0] acc_i,
  input logic [LANES-1:0]        mask_i,
  input logic                    mask_en_i,
  input logic                    zero_mode_i,
  input logic [VLEN_W-1:0]       vlen_i,
  input logic                    out_valid_o,
  input logic [LANES*LANE_W-1:0] result_o
);

  // Cycles since reset release, saturating, so $past stays post-reset
  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  assign warm = (warm_q == 2'd3);

  assert_reset_clears_R2: assert property (
    @(posedge clk_i) !rst_ni |-> !out_valid_o);

  assert_latency_R1: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    warm |-> (out_valid_o == $past(in_valid_i, 3)));

  for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
    localparam int unsigned PAIR = j / 2;

    assert_upper_clear_R5: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (warm && out_valid_o && (PAIR >= (32'd1 << $past(vlen_i, 3))))
      |-> (result_o[j*LANE_W +: LANE_W] == '0));

    assert_zero_mask_R8: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (warm && out_valid_o && $past(mask_en_i && zero_mode_i && !mask_i[j], 3))
      |-> (result_o[j*LANE_W +: LANE_W] == '0));

    assert_merge_keep_R9: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (warm && out_valid_o &&
       $past(mask_en_i && !zero_mode_i && !mask_i[j] &&
             (PAIR < (32'd1 << vlen_i)), 3))
      |-> (result_o[j*LANE_W +: LANE_W] == $past(acc_i[j*LANE_W +: LANE_W], 3)));
  end

endmodule

bind madd52lo_unit madd52lo_unit_chk #(
  .LANES  (LANES),
  .LANE_W (LANE_W),
  .VLEN_W (VLEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .acc_i       (acc_i),
  .mask_i      (mask_i),
  .mask_en_i   (mask_en_i),
  .zero_mode_i (zero_mode_i),
  .vlen_i      (vlen_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o)
);

// File: tb/madd52lo_unit_bench.sv
`timescale 1ns/1ps
module madd52lo_unit_bench;

  localparam int LANES  = 8;
  localparam int LANE_W = 64;
  localparam int MUL_W  = 52;
  localparam int VEC_W  = LANES * LANE_W;

  typedef struct packed {
    logic [7:0] mask;
    logic       men;
    logic       zm;
    logic       bc;
    logic [1:0] vl;
    logic       hi;
  } cfg_t;

  logic             clk;
  logic             rst_ni;
  logic             in_valid;
  logic [VEC_W-1:0] src_a;
  logic [VEC_W-1:0] src_b;
  logic [VEC_W-1:0] acc;
  logic [7:0]       mask;
  logic             men;
  logic             zm;
  logic             bc;
  logic [1:0]       vl;
  logic             out_valid;
  logic [VEC_W-1:0] result;

  int checks;
  int failures;
  int cycle;
  bit done;

  logic [VEC_W-1:0] exp_q[$];
  cfg_t             cfg_q[$];
  int               when_q[$];

  madd52lo_unit u_madd52lo_unit (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .src_a_i     (src_a),
    .src_b_i     (src_b),
    .acc_i       (acc),
    .mask_i      (mask),
    .mask_en_i   (men),
    .zero_mode_i (zm),
    .bcast_i     (bc),
    .vlen_i      (vl),
    .out_valid_o (out_valid),
    .result_o    (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [VEC_W-1:0] ref_model(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
                                                 logic [VEC_W-1:0] c, cfg_t cf);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int j = 0; j < LANES; j++) begin
      logic [103:0] fa, fb, full;
      logic [63:0]  cl;
      int           lim;
      lim = 2 << cf.vl;
      cl  = c[j*64 +: 64];
      fa  = {52'b0, a[j*64 +: 52]};
      fb  = cf.bc ? {52'b0, b[51:0]} : {52'b0, b[j*64 +: 52]};
      full = fa * fb;
      if (j >= lim)                   r[j*64 +: 64] = 64'b0;
      else if (cf.men && !cf.mask[j]) r[j*64 +: 64] = cf.zm ? 64'b0 : cl;
      else                            r[j*64 +: 64] = cl + {12'b0, full[51:0]};
    end
    return r;
  endfunction

  function automatic string lane_tag(cfg_t cf, int j);
    string t;
    if (j >= (2 << cf.vl))          t = "R5";
    else if (!cf.men)               t = "R6 R4";
    else if (cf.mask[j])            t = "R7 R4";
    else if (cf.zm)                 t = "R8";
    else                            t = "R9";
    if (cf.bc) t = {t, " R10"};
    if (cf.hi) t = {t, " R3"};
    return t;
  endfunction

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1 unexpected valid: actual=1 expected=0");
      end else begin
        logic [VEC_W-1:0] e;
        cfg_t cf;
        int   w;
        e  = exp_q.pop_front();
        cf = cfg_q.pop_front();
        w  = when_q.pop_front();
        checks++;
        if (cycle != w + 3) begin
          failures++;
          $display("FAIL R1 latency: actual=%0d expected=%0d", cycle - w, 3);
        end
        for (int j = 0; j < LANES; j++) begin
          checks++;
          if (result[j*64 +: 64] !== e[j*64 +: 64]) begin
            failures++;
            $display("FAIL %s lane %0d: actual=%h expected=%h",
                     lane_tag(cf, j), j, result[j*64 +: 64], e[j*64 +: 64]);
          end
        end
      end
    end
  end

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic issue(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, logic [VEC_W-1:0] c, cfg_t cf);
    @(negedge clk);
    src_a = a; src_b = b; acc = c;
    mask = cf.mask; men = cf.men; zm = cf.zm; bc = cf.bc; vl = cf.vl;
    in_valid = 1'b1;
    exp_q.push_back(ref_model(a, b, c, cf));
    cfg_q.push_back(cf);
    when_q.push_back(cycle);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    src_a = '1; src_b = '1; acc = '1;
  endtask

  function automatic logic [7:0] mask_pick(int i);
    case (i)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      default: return 8'h3C;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int n;
    checks = 0; failures = 0; done = 1'b0; n = 0;
    rst_ni = 1'b1; in_valid = 1'b0;
    src_a = '0; src_b = '0; acc = '0;
    mask = '0; men = 1'b0; zm = 1'b0; bc = 1'b0; vl = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R2 valid in reset", out_valid, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R2 valid idle after reset", out_valid, 1'b0);

    for (int v = 0; v < 4; v++)
      for (int me = 0; me < 2; me++)
        for (int z = 0; z < 2; z++)
          for (int b = 0; b < 2; b++)
            for (int mi = 0; mi < 4; mi++)
              for (int p = 0; p < 4; p++) begin
                logic [VEC_W-1:0] a, bb, c;
                cfg_t cf;
                cf.mask = mask_pick(mi);
                cf.men = me[0]; cf.zm = z[0]; cf.bc = b[0]; cf.vl = v[1:0];
                case (p)
                  0: begin a = '1; bb = '1; c = '1; cf.hi = 1'b1; end
                  1: begin a = rnd_vec(); bb = rnd_vec(); c = rnd_vec(); cf.hi = 1'b1; end
                  2: begin
                    a = rnd_vec(); bb = rnd_vec(); c = rnd_vec(); cf.hi = 1'b0;
                    for (int j = 0; j < LANES; j++) begin
                      a[j*64+52 +: 12] = '0; bb[j*64+52 +: 12] = '0;
                    end
                  end
                  default: begin
                    a = rnd_vec(); bb = rnd_vec(); c = rnd_vec(); cf.hi = 1'b1;
                    for (int j = 0; j < LANES; j++) c[j*64+12 +: 52] = '1;
                  end
                endcase
                issue(a, bb, c, cf);
                n++;
                if (n % 7 == 3) idle();
              end
    idle();
    repeat (6) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results: actual=%0d expected=0", exp_q.size());
    end

    // Reset with an operation in flight
    begin
      cfg_t cf;
      cf = '{mask: 8'hFF, men: 1'b0, zm: 1'b0, bc: 1'b0, vl: 2'd2, hi: 1'b0};
      issue('1, '1, '1, cf);
      idle();
      rst_ni = 1'b0;
      exp_q.delete(); cfg_q.delete(); when_q.delete();
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check_bit("R2 valid during reset", out_valid, 1'b0);
      end
      rst_ni = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check_bit("R2 flushed op stays invalid", out_valid, 1'b0);
      end
    end
    finish_run();
  end

endmodule